// File: doc/BRIEF.md
# Two-Level Aperture Address Remapper

This block translates bus addresses that fall inside a programmable aperture window into physical page addresses. Translation goes through a two-level table held in system memory. The upper ten address bits select a directory word, which points to a second-level table. The middle ten bits select a page word in that table. The low twelve bits pass through unchanged. An eight-entry fully associative translation cache holds recent page translations, so a repeated lookup costs no memory traffic.

Software programs the block through a small write port. That port sets the directory base, the aperture base, the remap enable bit and a flush command. A separate configuration input selects the window size and gates translation. Lookups arrive on a valid/ready request port and complete with a single-cycle response pulse. A miss walks the table through a memory read port. The read port allows one request at a time, and each request is answered by a response pulse.

Top module: `apr_remap_top`

## Requirements
- R1: When the address is outside the window, or when translation is off, the lookup completes with `rsp_addr` equal to the request address and no memory read. The response appears in the cycle after acceptance. Translation is off when `cfg_word[0]` is 0 or when enable register bit 2 (register offset 0x2) is 0.
- R2: A miss issues two memory reads. The first reads the directory word at `{base[31:12],12'h000} + 4*addr[31:22]`, where base is the register at offset 0x4. The second reads the page word at `{dir[31:12],12'h000} + 4*addr[21:12]`. The response is `{page[31:12], addr[11:0]}`, five cycles after acceptance.
- R3: A directory word with bit 0 clear ends the walk after one read. The response has `rsp_fault` high and `rsp_addr` zero, and nothing is cached.
- R4: A page word with bit 0 clear gives a fault response with `rsp_addr` zero, and nothing is cached.
- R5: A lookup of a cached page returns its translation one cycle after acceptance, with no memory read.
- R6: `cfg_word[3:1]` = k selects a window of 32 MiB shifted left by k, aligned on the aperture base (register offset 0x8). Codes 6 and 7 both mean 2 GiB.
- R7: A write to offset 0xC with data bit 0 set invalidates every cached translation. The same write with bit 0 clear leaves the cache intact.
- R8: A flush that arrives during a walk still lets that walk respond with its translation, but the result is not cached.
- R9: Cache fills use round-robin order. After nine distinct pages are filled, the first page misses and the third page still hits.
- R10: At most one walk is active. `req_ready` is low while a walk is active, and `mem_req` is a single-cycle pulse per read.
- R11: After reset, `rsp_valid` and `mem_req` are low, `req_ready` is high, and translation is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 4 | Register offset (0x2 enable, 0x4 directory base, 0x8 aperture base, 0xC flush) |
| reg_data | input | 32 | Register write data |
| cfg_word | input | 4 | Bit 0 translation gate, bits 3:1 window size code |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | 32 | Table read address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table read data |

## Verification
A corrupted cache entry or round-robin pointer shows up at the ports in one of two ways. The response address may be wrong on the very next cycle after a hit. Or the number of memory reads may not match the hit or miss the bench expects. The bench therefore counts reads and measures latency on every lookup. A walker stuck in a busy state keeps `req_ready` low, and the next lookup times out. A lost flush shows as a one-cycle response where a five-cycle miss was due. A bad window mask makes an address near the window edge come back unchanged when it should have been translated, or the reverse.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int AW = 32;
  localparam int PGW = 12;
  localparam int FRW = AW - PGW;

  typedef enum logic [2:0] {WK_IDLE, WK_DREQ, WK_DWAIT, WK_TREQ, WK_TWAIT} walk_st_e;

  // window byte mask for a size code; codes 6 and 7 both give 2 GiB
  function automatic logic [AW-1:0] win_mask(input logic [2:0] code);
    logic [2:0] k;
    k = (code == 3'd7) ? 3'd6 : code;
    return (32'h0200_0000 << k) - 32'd1;
  endfunction

  function automatic logic [AW-1:0] dir_ptr(input logic [AW-1:0] base, input logic [AW-1:0] va);
    return {base[AW-1:PGW], 12'h000} + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [AW-1:0] pte_ptr(input logic [AW-1:0] dent, input logic [AW-1:0] va);
    return {dent[AW-1:PGW], 12'h000} + {20'd0, va[21:12], 2'b00};
  endfunction
endpackage

// File: rtl/apr_regs.sv
module apr_regs
  import apr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    off,
  input  logic [AW-1:0] data,
  output logic [AW-1:0] dir_base,
  output logic [AW-1:0] win_base,
  output logic          remap_on,
  output logic          flush
);
  localparam logic [3:0] OFF_ENA   = 4'h2;
  localparam logic [3:0] OFF_DIR   = 4'h4;
  localparam logic [3:0] OFF_WIN   = 4'h8;
  localparam logic [3:0] OFF_FLUSH = 4'hC;

  assign flush = wr && (off == OFF_FLUSH) && data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_base <= '0;
      win_base <= '0;
      remap_on <= 1'b0;
    end else if (wr) begin
      if (off == OFF_ENA) remap_on <= data[2];
      if (off == OFF_DIR) dir_base <= data;
      if (off == OFF_WIN) win_base <= data;
    end
  end
endmodule

// File: rtl/apr_tlb.sv
module apr_tlb
  import apr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FRW-1:0]   lk_tag,
  output logic             hit,
  output logic [FRW-1:0]   hit_frame,
  input  logic             fill,
  input  logic [FRW-1:0]   fill_tag,
  input  logic [FRW-1:0]   fill_frame,
  input  logic             flush,
  output logic [DEPTH-1:0] vld
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FRW-1:0] tag_q [DEPTH];
  logic [FRW-1:0] frm_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic [PW-1:0] rr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = vld[g] && (tag_q[g] == lk_tag);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        tag_q[g] <= '0;
        frm_q[g] <= '0;
      end else if (flush) begin
        vld[g] <= 1'b0;
      end else if (fill && rr_q == PW'(g)) begin
        vld[g]   <= 1'b1;
        tag_q[g] <= fill_tag;
        frm_q[g] <= fill_frame;
      end
    end
  end

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_frame = frm_q[i];
  end
  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (fill && !flush) rr_q <= (rr_q == PW'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/apr_walker.sv
module apr_walker
  import apr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  va_in,
  input  logic [AW-1:0]  dir_base,
  input  logic           flush,
  output logic           busy,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rsp_valid,
  input  logic [AW-1:0]  mem_rsp_data,
  output logic           done,
  output logic           done_fault,
  output logic [AW-1:0]  done_phys,
  output logic           fill,
  output logic [FRW-1:0] fill_tag,
  output logic [FRW-1:0] fill_frame
);
  walk_st_e st_q;
  logic [AW-1:0] va_q, tptr_q;
  logic kill_q;
  logic dir_ret, pte_ret;

  assign busy     = (st_q != WK_IDLE);
  assign mem_req  = (st_q == WK_DREQ) || (st_q == WK_TREQ);
  assign mem_addr = (st_q == WK_TREQ) ? tptr_q : dir_ptr(dir_base, va_q);
  assign dir_ret  = (st_q == WK_DWAIT) && mem_rsp_valid;
  assign pte_ret  = (st_q == WK_TWAIT) && mem_rsp_valid;

  assign done       = (dir_ret && !mem_rsp_data[0]) || pte_ret;
  assign done_fault = !mem_rsp_data[0];
  assign done_phys  = (pte_ret && mem_rsp_data[0]) ? {mem_rsp_data[AW-1:PGW], va_q[PGW-1:0]} : '0;
  assign fill       = pte_ret && mem_rsp_data[0] && !kill_q && !flush;
  assign fill_tag   = va_q[AW-1:PGW];
  assign fill_frame = mem_rsp_data[AW-1:PGW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      va_q   <= '0;
      tptr_q <= '0;
      kill_q <= 1'b0;
    end else begin
      if (start) kill_q <= 1'b0;
      else if (flush && busy) kill_q <= 1'b1;
      unique case (st_q)
        WK_IDLE:  if (start) begin st_q <= WK_DREQ; va_q <= va_in; end
        WK_DREQ:  st_q <= WK_DWAIT;
        WK_DWAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                      tptr_q <= pte_ptr(mem_rsp_data, va_q);
                      st_q   <= WK_TREQ;
                    end else st_q <= WK_IDLE;
                  end
        WK_TREQ:  st_q <= WK_TWAIT;
        WK_TWAIT: if (mem_rsp_valid) st_q <= WK_IDLE;
        default:  st_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apr_remap_top.sv
module apr_remap_top
  import apr_pkg::*;
#(
  parameter int TLB_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_off,
  input  logic [31:0]   reg_data,
  input  logic [3:0]    cfg_word,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic [31:0]   rsp_addr,
  output logic          rsp_fault,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data
);
  logic [AW-1:0] dir_base, win_base;
  logic remap_on, flush_evt;
  logic xl_on, in_win, accept, acc_pass, acc_hit, acc_miss;
  logic tlb_hit, fill;
  logic [FRW-1:0] hit_frame, fill_tag, fill_frame;
  logic [TLB_DEPTH-1:0] tlb_vld;
  logic walk_busy, done, done_fault;
  logic [AW-1:0] done_phys;

  apr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(reg_off), .data(reg_data),
    .dir_base(dir_base), .win_base(win_base), .remap_on(remap_on), .flush(flush_evt)
  );

  assign xl_on    = remap_on && cfg_word[0];
  assign in_win   = ((req_addr ^ win_base) & ~win_mask(cfg_word[3:1])) == '0;
  assign req_ready = !walk_busy;
  assign accept   = req_valid && req_ready;
  assign acc_pass = accept && !(xl_on && in_win);
  assign acc_hit  = accept && xl_on && in_win && tlb_hit;
  assign acc_miss = accept && xl_on && in_win && !tlb_hit;

  apr_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_tag(req_addr[AW-1:PGW]), .hit(tlb_hit),
    .hit_frame(hit_frame), .fill(fill), .fill_tag(fill_tag),
    .fill_frame(fill_frame), .flush(flush_evt), .vld(tlb_vld)
  );

  apr_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(acc_miss), .va_in(req_addr),
    .dir_base(dir_base), .flush(flush_evt), .busy(walk_busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_phys(done_phys), .fill(fill), .fill_tag(fill_tag), .fill_frame(fill_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= acc_pass || acc_hit || done;
      rsp_fault <= done && done_fault;
      if (acc_pass)     rsp_addr <= req_addr;
      else if (acc_hit) rsp_addr <= {hit_frame, req_addr[PGW-1:0]};
      else if (done)    rsp_addr <= done_phys;
    end
  end
endmodule

// File: rtl/apr_remap_chk.sv
module apr_remap_chk #(
  parameter int TLB_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic [31:0]          req_addr,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_addr,
  input logic                 rsp_fault,
  input logic                 mem_req,
  input logic                 acc_pass,
  input logic                 acc_hit,
  input logic                 flush_evt,
  input logic [TLB_DEPTH-1:0] tlb_vld
);
  AST_PASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pass |=> rsp_valid && !rsp_fault && rsp_addr == $past(req_addr)); // R1
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> rsp_valid && !rsp_fault && !mem_req); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> tlb_vld == '0); // R7
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10
  AST_FAULT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_addr == '0); // R3
endmodule

bind apr_remap_top apr_remap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
  .mem_req(mem_req), .acc_pass(acc_pass), .acc_hit(acc_hit),
  .flush_evt(flush_evt), .tlb_vld(tlb_vld)
);

// File: tb/apr_remap_top_tb_top.sv
module apr_remap_top_tb_top;
  localparam logic [31:0] DIRB = 32'h0010_0000;
  localparam logic [31:0] WINB = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [3:0] reg_off = 0; logic [31:0] reg_data = 0;
  logic [3:0] cfg_word = 0;
  logic req_valid = 0, req_ready; logic [31:0] req_addr = 0;
  logic rsp_valid, rsp_fault; logic [31:0] rsp_addr;
  logic mem_req; logic [31:0] mem_addr;
  logic mem_rsp_valid; logic [31:0] mem_rsp_data;
  int n_cmp = 0, n_bad = 0, mem_reads = 0;
  logic [31:0] bad_pte = 32'hFFFF_FFFF;
  bit ended = 0;

  always #2 clk = ~clk;

  apr_remap_top dut_i (.*);

  // memory image computed from the address; directory index 0x3F0 is invalid
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a >= DIRB && a < DIRB + 32'h1000)
      return (a[11:2] == 10'h3F0) ? 32'h0 : {10'h1C0, a[11:2], 12'h001};
    return (a == bad_pte) ? 32'h0 : {a[21:2] ^ 20'hA5A5A, 12'h001};
  endfunction

  function automatic logic [31:0] pte_at(input logic [31:0] va);
    logic [31:0] d;
    d = mem_word(DIRB + 32'(va[31:22]) * 4);
    return (d & 32'hFFFF_F000) + 32'(va[21:12]) * 4;
  endfunction

  function automatic logic [31:0] xlate(input logic [31:0] va);
    return (mem_word(pte_at(va)) & 32'hFFFF_F000) | (va & 32'hFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin mem_rsp_valid <= 0; mem_rsp_data <= 0; end
    else begin
      mem_rsp_valid <= mem_req;
      mem_rsp_data  <= mem_word(mem_addr);
      if (mem_req) mem_reads <= mem_reads + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_off = o; reg_data = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic look(input logic [31:0] va, output logic [31:0] ra, output logic f,
                      output int lat, output int rd, output logic rdy1);
    int r0;
    @(negedge clk); req_valid = 1; req_addr = va; r0 = mem_reads;
    @(negedge clk); req_valid = 0; lat = 1; rdy1 = req_ready;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    ra = rsp_addr; f = rsp_fault; rd = mem_reads - r0;
  endtask

  // {size code, in-window flag, address}
  localparam logic [35:0] VEC [12] = '{
    {3'd0, 1'b1, 32'h81FF_F004}, {3'd0, 1'b0, 32'h8200_0000},
    {3'd1, 1'b1, 32'h83FF_FFFC}, {3'd1, 1'b0, 32'h8400_0000},
    {3'd3, 1'b1, 32'h8FFF_0000}, {3'd3, 1'b0, 32'h9000_0000},
    {3'd6, 1'b1, 32'hFFFF_F123}, {3'd6, 1'b0, 32'h7FFF_FFFF},
    {3'd7, 1'b1, 32'hC000_0000}, {3'd2, 1'b1, 32'h8700_0010},
    {3'd2, 1'b0, 32'h8800_0010}, {3'd5, 1'b1, 32'hBFFF_F000}};

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra; logic f, rdy; int lat, rd;
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 req_ready", 32'(req_ready), 1);
    rst_n = 1;
    wreg(4'h4, DIRB); wreg(4'h8, WINB);
    cfg_word = 4'b0001;
    look(32'h8000_1234, ra, f, lat, rd, rdy);
    chk("R11 off after reset", ra, 32'h8000_1234);
    chk("R1 no read when disabled", 32'(rd), 0);
    wreg(4'h2, 32'h4);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] va, ex;
      va = VEC[i][31:0];
      cfg_word = {VEC[i][35:33], 1'b1};
      ex = VEC[i][32] ? xlate(va) : va;
      look(va, ra, f, lat, rd, rdy);
      chk($sformatf("R6 vec%0d addr", i), ra, ex);
      chk($sformatf("R6 vec%0d fault", i), 32'(f), 0);
    end

    cfg_word = 4'b1101; wreg(4'hC, 1);
    look(32'h8123_4567, ra, f, lat, rd, rdy);
    chk("R2 miss addr", ra, xlate(32'h8123_4567));
    chk("R2 miss latency", 32'(lat), 5);
    chk("R2 miss reads", 32'(rd), 2);
    chk("R10 ready low in walk", 32'(rdy), 0);
    look(32'h8123_4ABC, ra, f, lat, rd, rdy);
    chk("R5 hit addr", ra, xlate(32'h8123_4ABC));
    chk("R5 hit latency", 32'(lat), 1);
    chk("R5 hit reads", 32'(rd), 0);
    wreg(4'hC, 0);
    look(32'h8123_4000, ra, f, lat, rd, rdy);
    chk("R7 bit0 clear keeps cache", 32'(rd), 0);
    wreg(4'hC, 1);
    look(32'h8123_4000, ra, f, lat, rd, rdy);
    chk("R7 flush forces miss", 32'(rd), 2);

    cfg_word = 4'b1100;
    look(32'h8123_4000, ra, f, lat, rd, rdy);
    chk("R1 gate off passes", ra, 32'h8123_4000);
    chk("R1 gate off latency", 32'(lat), 1);
    cfg_word = 4'b1101;
    look(32'h7000_0000, ra, f, lat, rd, rdy);
    chk("R1 outside passes", ra, 32'h7000_0000);
    chk("R1 outside reads", 32'(rd), 0);

    look(32'hFC00_0010, ra, f, lat, rd, rdy);
    chk("R3 dir fault flag", 32'(f), 1);
    chk("R3 dir fault addr", ra, 0);
    chk("R3 dir fault reads", 32'(rd), 1);
    look(32'hFC00_0010, ra, f, lat, rd, rdy);
    chk("R3 not cached", 32'(rd), 1);

    bad_pte = pte_at(32'h9000_5000);
    look(32'h9000_5000, ra, f, lat, rd, rdy);
    chk("R4 pte fault flag", 32'(f), 1);
    chk("R4 pte fault addr", ra, 0);
    look(32'h9000_5000, ra, f, lat, rd, rdy);
    chk("R4 not cached", 32'(rd), 2);

    @(negedge clk); req_valid = 1; req_addr = 32'hA000_3000;
    @(negedge clk); req_valid = 0; reg_wr = 1; reg_off = 4'hC; reg_data = 1;
    @(negedge clk); reg_wr = 0;
    while (!rsp_valid) @(negedge clk);
    chk("R8 walk still answers", rsp_addr, xlate(32'hA000_3000));
    look(32'hA000_3000, ra, f, lat, rd, rdy);
    chk("R8 result not cached", 32'(rd), 2);

    wreg(4'hC, 1);
    for (int p = 0; p < 9; p++) look(32'hB000_0000 + 32'(p) * 32'h1000, ra, f, lat, rd, rdy);
    look(32'hB000_2000, ra, f, lat, rd, rdy);
    chk("R9 third page hits", 32'(rd), 0);
    chk("R9 third page addr", ra, xlate(32'hB000_2000));
    look(32'hB000_0000, ra, f, lat, rd, rdy);
    chk("R9 first page evicted", 32'(rd), 2);

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule